// File: doc/BRIEF.md
# Transport packet sync lock detector

This block sits on the byte stream that leaves an inner channel decoder and finds where each transport packet begins. Two framings are supported. In the long framing (DVB), packets are 204 bytes and the leading byte is 0x47, or its bitwise complement 0xB8 on the first packet of each group of eight. In the short framing (DSS), packets are 147 bytes and the leading byte is 0x1D.

A bounded up/down confidence counter tracks how well the stream keeps its framing. Each sync byte found at its expected slot raises the counter. Each expected slot without a sync byte lowers it. When the counter reaches a programmable ceiling the lock flag rises. The flag stays up until the counter has drained all the way to zero. While the counter is zero the block hunts at every byte. Once a candidate is found, only the bytes a whole number of packet lengths later are examined.

Downstream logic uses the lock flag, a packet-start pulse and a packet index within the eight-packet group to frame later decoding stages.

Top module: `pkt_sync_lock`

## Requirements
- R1: With `mode_dss_i`=0 the packet length is 204 and bytes 0x47 and 0xB8 are sync values. With `mode_dss_i`=1 the length is 147 and only 0x1D is a sync value, so 0x47 and 0xB8 are ordinary data.
- R2: While the counter is zero, any valid byte holding a sync value becomes a candidate. The counter goes to 1, and the next byte is taken as packet position 1.
- R3: While the counter is non-zero, only the byte at position 0 of each packet is examined. A sync value at any other position has no effect.
- R4: A sync value at position 0 increments the counter, saturating at the ceiling. A non-sync byte at position 0 decrements it, saturating at zero.
- R5: `lock_o` goes to 1 in the cycle after the byte that brings the counter to the ceiling. A `thresh_i` of 0 acts as a ceiling of 1.
- R6: Once set, `lock_o` returns to 0 only in the cycle after the byte that brings the counter to zero.
- R7: `pkt_start_o` is high for exactly one cycle, the cycle after each accepted sync byte (a candidate or a hit at position 0). A missed slot gives no pulse.
- R8: At every candidate and every examined position-0 byte, `pkt_idx_o` (3 bits) becomes 0 if the byte is 0xB8 in DVB mode. Otherwise it increments modulo 8. The new value appears in the following cycle.
- R9: A cycle with `valid_i`=0 changes no state and no output except clearing `pkt_start_o`.
- R10: `rst_ni`=0 (asynchronous) or `srst_i`=1 (at a clock edge) clears the counter, the lock flag, the byte position, `pkt_idx_o` and `pkt_start_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous clear |
| valid_i | input | 1 | Byte strobe for data_i |
| data_i | input | 8 | Stream byte |
| mode_dss_i | input | 1 | 0: 204-byte framing, 1: 147-byte framing |
| thresh_i | input | CNT_W | Lock ceiling of the confidence counter |
| lock_o | output | 1 | Lock flag |
| pkt_start_o | output | 1 | One-cycle pulse after an accepted sync byte |
| pkt_idx_o | output | 3 | Packet index within the eight-packet group |

## Verification
The hardest case to reach is the release edge of the hysteresis. That edge only tells a counter that saturates from one that does not when the stream first drives the counter well past the ceiling and then withholds sync bytes exactly the ceiling's number of times. The bench therefore sweeps several ceilings in both framings. For each one it sends three more good packets than the ceiling needs, then drops exactly that many sync bytes and checks the flag on each side of the release. False candidates in the hunt state are created by placing a lone sync value ahead of the real framing.

// File: rtl/pkt_sync_pkg.sv
`timescale 1ns/1ps
package pkt_sync_pkg;
  localparam logic [7:0] LONG_SYNC     = 8'h47;
  localparam logic [7:0] LONG_SYNC_INV = ~8'h47;
  localparam logic [7:0] SHORT_SYNC    = 8'h1D;

  typedef enum logic [1:0] {
    MATCH_NONE,
    MATCH_PLAIN,
    MATCH_GROUP
  } match_e;
endpackage

// File: rtl/pkt_sync_match.sv
`timescale 1ns/1ps
module pkt_sync_match
  import pkt_sync_pkg::*;
(
  input  logic [7:0] data_i,
  input  logic       mode_dss_i,
  output match_e     match_o
);
  always_comb begin
    match_o = MATCH_NONE;
    if (mode_dss_i) begin
      if (data_i == SHORT_SYNC) match_o = MATCH_PLAIN;
    end else if (data_i == LONG_SYNC) begin
      match_o = MATCH_PLAIN;
    end else if (data_i == LONG_SYNC_INV) begin
      match_o = MATCH_GROUP;
    end
  end
endmodule

// File: rtl/pkt_pos_ctr.sv
`timescale 1ns/1ps
module pkt_pos_ctr #(
  parameter int unsigned LEN_LONG  = 204,
  parameter int unsigned LEN_SHORT = 147
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic mode_dss_i,
  input  logic load_i,
  input  logic step_i,
  output logic at_slot_o
);
  localparam int unsigned MAX_LEN = (LEN_LONG > LEN_SHORT) ? LEN_LONG : LEN_SHORT;
  localparam int unsigned POS_W   = $clog2(MAX_LEN);

  logic [POS_W-1:0] pos_q, last;

  assign last      = mode_dss_i ? POS_W'(LEN_SHORT - 1) : POS_W'(LEN_LONG - 1);
  assign at_slot_o = (pos_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pos_q <= '0;
    else if (srst_i)      pos_q <= '0;
    else if (load_i)      pos_q <= POS_W'(1);
    else if (step_i)      pos_q <= (pos_q >= last) ? '0 : pos_q + 1'b1;
  end

  // R9
  pos_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srst_i && !load_i && !step_i |=> $stable(pos_q));
endmodule

// File: rtl/pkt_lock_ctr.sv
`timescale 1ns/1ps
module pkt_lock_ctr #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic [CNT_W-1:0] ceil_i,
  input  logic             up_i,
  input  logic             down_i,
  output logic             zero_o,
  output logic             lock_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, ceil_eff;
  logic             lock_q, lock_d;

  assign ceil_eff = (ceil_i == '0) ? CNT_W'(1) : ceil_i;
  assign zero_o   = (cnt_q == '0);
  assign lock_o   = lock_q;

  always_comb begin
    cnt_d = cnt_q;
    if (up_i) begin
      if (cnt_q < ceil_eff) cnt_d = cnt_q + 1'b1;
    end else if (down_i) begin
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end
    lock_d = lock_q;
    if (cnt_d == ceil_eff)  lock_d = 1'b1;
    else if (cnt_d == '0)   lock_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (srst_i) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= ceil_eff);
  // R4
  unit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(srst_i) && (cnt_q != $past(cnt_q)) |->
      (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q + 1'b1 == $past(cnt_q)));
  // R5
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> cnt_q == ceil_eff);
  // R6
  lock_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_q) |-> cnt_q == '0);
endmodule

// File: rtl/pkt_sync_lock.sv
`timescale 1ns/1ps
module pkt_sync_lock
  import pkt_sync_pkg::*;
#(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned LEN_LONG  = 204,
  parameter int unsigned LEN_SHORT = 147,
  parameter int unsigned GROUP_LEN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             valid_i,
  input  logic [7:0]       data_i,
  input  logic             mode_dss_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             lock_o,
  output logic             pkt_start_o,
  output logic [2:0]       pkt_idx_o
);
  localparam int unsigned IDX_W = $clog2(GROUP_LEN);

  match_e           match;
  logic             is_sync, zero, at_slot;
  logic             hunt_hit, slot, up, down;
  logic             start_q;
  logic [IDX_W-1:0] idx_q;

  pkt_sync_match u_match (
    .data_i     (data_i),
    .mode_dss_i (mode_dss_i),
    .match_o    (match)
  );

  pkt_pos_ctr #(
    .LEN_LONG  (LEN_LONG),
    .LEN_SHORT (LEN_SHORT)
  ) u_pos (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .srst_i     (srst_i),
    .mode_dss_i (mode_dss_i),
    .load_i     (hunt_hit),
    .step_i     (valid_i && !zero),
    .at_slot_o  (at_slot)
  );

  pkt_lock_ctr #(.CNT_W(CNT_W)) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .srst_i (srst_i),
    .ceil_i (thresh_i),
    .up_i   (up),
    .down_i (down),
    .zero_o (zero),
    .lock_o (lock_o)
  );

  assign is_sync  = (match != MATCH_NONE);
  assign hunt_hit = valid_i && zero && is_sync;
  assign slot     = valid_i && !zero && at_slot;
  assign up       = hunt_hit || (slot && is_sync);
  assign down     = slot && !is_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      idx_q   <= '0;
    end else if (srst_i) begin
      start_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      start_q <= up;
      if (hunt_hit || slot)
        idx_q <= (match == MATCH_GROUP || idx_q == IDX_W'(GROUP_LEN - 1)) ? '0 : idx_q + 1'b1;
    end
  end

  assign pkt_start_o = start_q;
  assign pkt_idx_o   = 3'(idx_q);

  // R2
  hunt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srst_i && valid_i && zero && is_sync |=> pkt_start_o);
  // R7
  start_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_o |-> $past(valid_i));
  // R8
  group_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_o && $past(!mode_dss_i && data_i == 8'hB8) |-> pkt_idx_o == 3'd0);
  // R9
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && !srst_i |=> !pkt_start_o && $stable(pkt_idx_o) && $stable(lock_o));
endmodule

// File: tb/tb_pkt_sync_lock.sv
`timescale 1ns/1ps
module tb_pkt_sync_lock;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0, srst_i = 1'b0, valid_i = 1'b0, mode_dss_i = 1'b0;
  logic [7:0]    data_i = 8'h00;
  logic [CW-1:0] thresh_i = 4'd1;
  logic          lock_o, pkt_start_o;
  logic [2:0]    pkt_idx_o;

  int checks = 0, fails = 0, cyc = 0, fc = 0;
  int m_cnt = 0, m_pos = 0, m_idx = 0;
  bit m_lock = 0, m_start = 0, gap_en = 0;
  string tag = "R10";

  always #2.5 clk = ~clk;

  pkt_sync_lock #(.CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .srst_i(srst_i), .valid_i(valid_i),
    .data_i(data_i), .mode_dss_i(mode_dss_i), .thresh_i(thresh_i),
    .lock_o(lock_o), .pkt_start_o(pkt_start_o), .pkt_idx_o(pkt_idx_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, tag, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R5 R6 lock", int'(lock_o), int'(m_lock));
    chk("R7 start", int'(pkt_start_o), int'(m_start));
    chk("R8 idx", int'(pkt_idx_o), m_idx);
  endtask

  function automatic bit sync_val(logic [7:0] d, bit dss);
    return dss ? (d == 8'h1D) : (d == 8'h47 || d == 8'hB8);
  endfunction

  task automatic model_step(logic [7:0] d, bit v);
    int mx, len;
    bit s;
    mx  = (thresh_i == 0) ? 1 : int'(thresh_i);
    len = mode_dss_i ? 147 : 204;
    s   = sync_val(d, mode_dss_i);
    m_start = 0;
    if (!v) return;
    if (m_cnt == 0) begin
      if (s) begin
        m_cnt = 1; m_pos = 1; m_start = 1;
        m_idx = (!mode_dss_i && d == 8'hB8) ? 0 : (m_idx + 1) % 8;
      end
    end else begin
      if (m_pos == 0) begin
        m_idx = (!mode_dss_i && d == 8'hB8) ? 0 : (m_idx + 1) % 8;
        if (s) begin
          if (m_cnt < mx) m_cnt++;
          m_start = 1;
        end else m_cnt--;
      end
      m_pos = (m_pos >= len - 1) ? 0 : m_pos + 1;
    end
    if (m_cnt == mx) m_lock = 1;
    else if (m_cnt == 0) m_lock = 0;
  endtask

  task automatic drive(logic [7:0] d, bit v);
    @(negedge clk);
    cmp_all();
    data_i = d; valid_i = v;
    model_step(d, v);
  endtask

  task automatic flush();
    drive(8'h00, 0);
    @(negedge clk);
    cmp_all();
  endtask

  task automatic do_srst(int th, bit dss);
    @(negedge clk);
    cmp_all();
    srst_i = 1; valid_i = 0;
    @(negedge clk);
    srst_i = 0; thresh_i = CW'(th); mode_dss_i = dss;
    m_cnt = 0; m_pos = 0; m_idx = 0; m_lock = 0; m_start = 0; fc = 0;
  endtask

  function automatic logic [7:0] payload(int i);
    logic [7:0] b;
    b = 8'((i * 37 + fc * 11 + 5) & 255);
    if (b == 8'h47 || b == 8'hB8 || b == 8'h1D) b = b ^ 8'h80;
    return b;
  endfunction

  task automatic send_pkt(bit good, int stray_pos = -1, logic [7:0] stray = 8'h00);
    int len;
    logic [7:0] s;
    len = mode_dss_i ? 147 : 204;
    s = mode_dss_i ? 8'h1D : ((fc % 8 == 0) ? 8'hB8 : 8'h47);
    drive(good ? s : 8'h00, 1);
    for (int i = 1; i < len; i++) begin
      drive((i == stray_pos) ? stray : payload(i), 1);
      if (gap_en && i % 3 == 0) drive(mode_dss_i ? 8'h1D : 8'h47, 0);
    end
    fc++;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      fails++;
      $display("FAIL watchdog [%s] actual=%0d expected=%0d", tag, cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int ths[6] = '{1, 2, 3, 5, 8, 15};
    repeat (3) @(negedge clk);
    // R10: asynchronous reset state
    chk("R10 lock", int'(lock_o), 0);
    chk("R10 start", int'(pkt_start_o), 0);
    chk("R10 idx", int'(pkt_idx_o), 0);
    rst_ni = 1;

    // R1 R4 R5 R6: ceiling sweep in both framings
    for (int md = 0; md < 2; md++) begin
      foreach (ths[k]) begin
        tag = "R1 R4 sweep";
        do_srst(ths[k], md[0]);
        repeat (ths[k] + 3) send_pkt(1);
        flush();
        chk("R5 locked after ceiling", int'(lock_o), 1);
        send_pkt(0);
        flush();
        chk("R6 held after one miss", int'(lock_o), (ths[k] > 1) ? 1 : 0);
        repeat (ths[k] - 1) send_pkt(0);
        flush();
        chk("R4 R6 released at zero", int'(lock_o), 0);
      end
    end

    // R5: ceiling of 0 acts as 1
    tag = "R5 zero ceiling";
    do_srst(0, 0);
    send_pkt(1);
    flush();
    chk("R5 zero ceiling lock", int'(lock_o), 1);

    // R3: sync values off-slot are ignored while tracking
    tag = "R3";
    do_srst(3, 0);
    send_pkt(1);
    send_pkt(1, 50, 8'h47);
    send_pkt(1, 90, 8'hB8);
    send_pkt(1, 7, 8'h47);
    flush();
    chk("R3 lock kept", int'(lock_o), 1);
    chk("R3 idx", int'(pkt_idx_o), 3);

    // R2: false candidate in hunt, then real framing
    tag = "R2";
    do_srst(2, 1);
    drive(8'h1D, 1);
    for (int i = 0; i < 30; i++) drive(payload(i + 1), 1);
    repeat (4) send_pkt(1);
    flush();
    chk("R2 lock after false candidate", int'(lock_o), 1);

    // R1: long-framing sync values are data in short framing
    tag = "R1";
    do_srst(1, 1);
    for (int i = 0; i < 300; i++) drive((i % 2) ? 8'h47 : 8'hB8, 1);
    flush();
    chk("R1 no lock on foreign sync", int'(lock_o), 0);

    // R9: idle cycles between bytes
    tag = "R9";
    do_srst(3, 1);
    gap_en = 1;
    repeat (5) send_pkt(1);
    gap_en = 0;
    flush();
    chk("R9 lock through gaps", int'(lock_o), 1);

    // R8: group index over several groups
    tag = "R8";
    do_srst(2, 0);
    repeat (19) send_pkt(1);
    flush();
    chk("R8 idx after 19 packets", int'(pkt_idx_o), 2);

    // R10: synchronous clear while locked
    tag = "R10";
    do_srst(2, 0);
    flush();
    chk("R10 srst lock", int'(lock_o), 0);
    chk("R10 srst idx", int'(pkt_idx_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule